// File: doc/BRIEF.md
# Multi-Mode Continuous-Phase FSK Tone Synthesizer

This block turns a serial transmit bit into a digitally synthesized frequency-shift-keyed waveform. Each bit picks one of two tones. A two-bit mode input selects which tone pair is used. There are four pairs: the low-speed originate and answer channels, the 1200-baud main channel and the slow back channel. Data bits select the tone directly, with no scrambling or rate conversion in the path.

A 24-bit phase accumulator advances once per output sample. The tone frequency sets its step. The top eight phase bits address a 256-entry sine table, which produces signed 12-bit samples. The sample rate is fixed at 9600 Hz and is derived from the system clock by a divider. A one-cycle strobe marks each new sample. A bit or mode change alters only the step size, so the waveform never jumps in phase. While transmit is disabled, the stream carries zeros and the accumulator is cleared.

Top module: `vfsk_modulator`

## Requirements
- R1: With mode 2'b00, a data bit of 1 advances the phase by round(980·2^24/9600) per sample and a 0 by round(1180·2^24/9600).
- R2: With mode 2'b01, a 1 uses 1650 Hz and a 0 uses 1850 Hz, with steps computed as in R1.
- R3: With mode 2'b10, a 1 (mark) uses the lower tone, 1300 Hz, and a 0 uses 2100 Hz.
- R4: With mode 2'b11, a 1 (mark) uses 390 Hz and a 0 uses 450 Hz. The bit may be held for 128 samples (75 baud) with the phase continuing to advance.
- R5: A change of bit or mode between samples changes only the step. The accumulated phase carries over, so the next sample continues from the previous phase.
- R6: A sample taken while the transmit enable is low is exactly 0, and the accumulator restarts at phase 0. The first sample after enabling is therefore 0, because sin(0) = 0.
- R7: `smp_valid` is high for exactly one clock in every CLK_HZ/SAMPLE_HZ clocks, and `smp_out` changes only in a cycle where `smp_valid` is high.
- R8: Each enabled sample equals 2047·sin(2π·p/256) within ±6 LSB, where p is the top 8 bits of the 24-bit phase before the step is added. The magnitude never exceeds 2047.
- R9: While reset is asserted, and immediately after it is released, `smp_out` is 0 and `smp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Tone pair select (00, 01, 10, 11 as in R1 to R4) |
| tx_en | input | 1 | Transmit enable; when low, zero output and cleared phase |
| tx_bit | input | 1 | Data bit; 1 selects the mark tone |
| smp_valid | output | 1 | One-clock strobe per output sample |
| smp_out | output | 12 | Signed two's-complement sine sample |

## Verification
- **Wrong phase step:** a wrong step for any mode or bit value shifts every later sample of that run away from the model. The error grows sample by sample, so it shows within a few strobes.
- **Phase cleared on a bit change:** an accumulator that is wrongly cleared when the bit changes shows at the first strobe after the change, as a jump back to zero.
- **Stale phase after disable:** a phase that is not cleared while disabled shows as a non-zero first sample after re-enable.
- **Divider fault:** a faulty sample divider shows in the strobe spacing within one sample period.

// File: rtl/vfsk_pkg.sv
package vfsk_pkg;

    typedef enum logic [1:0] {
        MODE_LS_ORIG  = 2'd0,
        MODE_LS_ANS   = 2'd1,
        MODE_HS_MAIN  = 2'd2,
        MODE_HS_BACK  = 2'd3
    } fsk_mode_e;

    // Tone frequency in Hz for a mode and a bit value (1 = mark).
    function automatic int unsigned tone_hz(input fsk_mode_e m, input logic mark);
        case (m)
            MODE_LS_ORIG: return mark ? 980  : 1180;
            MODE_LS_ANS:  return mark ? 1650 : 1850;
            MODE_HS_MAIN: return mark ? 1300 : 2100;
            default:      return mark ? 390  : 450;
        endcase
    endfunction

    // Rounded phase step for a tone at a given sample rate and accumulator width.
    function automatic longint unsigned tone_step(input int unsigned freq_hz,
                                                  input int unsigned rate_hz,
                                                  input int unsigned acc_w);
        longint unsigned num;
        num = (longint'(freq_hz) << acc_w) + longint'(rate_hz / 2);
        return num / longint'(rate_hz);
    endfunction

endpackage

// File: rtl/vfsk_sample_timer.sv
module vfsk_sample_timer #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/vfsk_phase_acc.sv
module vfsk_phase_acc
    import vfsk_pkg::*;
#(
    parameter int unsigned PHASE_W   = 24,
    parameter int unsigned SAMPLE_HZ = 9600
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               en,
    input  logic [1:0]         mode,
    input  logic               bit_in,
    output logic [PHASE_W-1:0] phase
);
    localparam int unsigned N_STEP = 8;

    logic [PHASE_W-1:0] step_tbl [N_STEP];
    logic [PHASE_W-1:0] step;
    logic [PHASE_W-1:0] phase_d, phase_q;

    for (genvar i = 0; i < N_STEP; i++) begin : g_step
        localparam int unsigned IDX = i;
        assign step_tbl[i] = PHASE_W'(tone_step(
            tone_hz(fsk_mode_e'(IDX / 2), logic'(IDX % 2)), SAMPLE_HZ, PHASE_W));
    end

    always_comb begin
        step    = step_tbl[{mode, bit_in}];
        phase_d = phase_q;
        if (tick) phase_d = en ? phase_q + step : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/vfsk_sine_rom.sv
module vfsk_sine_rom #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned SAMP_W = 12
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [SAMP_W-1:0] value
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam longint     HALF  = longint'(DEPTH / 2);
    localparam longint     AMP   = (longint'(1) << (SAMP_W - 1)) - 1;

    // Rational sine approximation over a half period, sign from the top bit.
    function automatic longint sine_entry(input longint idx);
        longint k, u, den, mag;
        k   = idx % HALF;
        u   = k * (HALF - k);
        den = 5 * HALF * HALF - 4 * u;
        mag = (AMP * 16 * u + den / 2) / den;
        return (idx >= HALF) ? -mag : mag;
    endfunction

    logic signed [SAMP_W-1:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tab
        assign table_w[i] = SAMP_W'(sine_entry(longint'(i)));
    end

    assign value = table_w[addr];
endmodule

// File: rtl/vfsk_modulator.sv
module vfsk_modulator
    import vfsk_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 9_830_400,
    parameter int unsigned SAMPLE_HZ = 9600,
    parameter int unsigned PHASE_W   = 24,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SAMP_W    = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode,
    input  logic                     tx_en,
    input  logic                     tx_bit,
    output logic                     smp_valid,
    output logic signed [SAMP_W-1:0] smp_out
);
    localparam int unsigned DIV = CLK_HZ / SAMPLE_HZ;

    typedef struct packed {
        logic                     valid;
        logic signed [SAMP_W-1:0] sample;
    } out_t;

    logic                     tick;
    logic [PHASE_W-1:0]       phase;
    logic signed [SAMP_W-1:0] rom_val;
    out_t                     out_d, out_q;

    vfsk_sample_timer #(.DIV(DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    vfsk_phase_acc #(.PHASE_W(PHASE_W), .SAMPLE_HZ(SAMPLE_HZ)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (tx_en),
        .mode   (mode),
        .bit_in (tx_bit),
        .phase  (phase)
    );

    vfsk_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
        .addr  (phase[PHASE_W-1 -: ADDR_W]),
        .value (rom_val)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = tick;
        if (tick) out_d.sample = tx_en ? rom_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign smp_valid = out_q.valid;
    assign smp_out   = out_q.sample;
endmodule

// File: rtl/vfsk_modulator_chk.sv
module vfsk_modulator_chk #(
    parameter int unsigned DIV    = 1024,
    parameter int unsigned SAMP_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tx_en,
    input logic                     smp_valid,
    input logic signed [SAMP_W-1:0] smp_out
);
    localparam logic signed [SAMP_W-1:0] MAXV = SAMP_W'((1 << (SAMP_W - 1)) - 1);

    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (smp_valid) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && seen_q) |-> (gap_q == DIV - 1)); // R7

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> $stable(smp_out)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !$past(tx_en)) |-> (smp_out == '0)); // R6

    AST_AMPLITUDE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_out <= MAXV) && (smp_out >= -MAXV)); // R8
endmodule

bind vfsk_modulator vfsk_modulator_chk #(.DIV(DIV), .SAMP_W(SAMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .smp_valid (smp_valid),
    .smp_out   (smp_out)
);

// File: tb/vfsk_modulator_test.sv
module vfsk_modulator_test;
    localparam int unsigned CLK_HZ = 96_000;
    localparam int unsigned SR     = 9600;
    localparam int unsigned DIVB   = CLK_HZ / SR;
    localparam real         PI     = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic              tx_en = 1'b0;
    logic              tx_bit = 1'b0;
    logic              smp_valid;
    logic signed [11:0] smp_out;

    int tests = 0;
    int fails = 0;
    int unsigned ph_m = 0;
    logic [1:0] prev_mode = 2'd0;
    logic prev_bit = 1'b0, prev_en = 1'b0;
    int gap = 0;
    bit seen = 0;
    int n_samples = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vfsk_modulator #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SR)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en),
        .tx_bit(tx_bit), .smp_valid(smp_valid), .smp_out(smp_out)
    );

    function automatic real freq_of(input logic [1:0] m, input logic b);
        case (m)
            2'd0: return b ? 980.0  : 1180.0;
            2'd1: return b ? 1650.0 : 1850.0;
            2'd2: return b ? 1300.0 : 2100.0;
            default: return b ? 390.0 : 450.0;
        endcase
    endfunction

    function automatic int unsigned step_of(input logic [1:0] m, input logic b);
        return $rtoi(freq_of(m, b) * 16777216.0 / 9600.0 + 0.5);
    endfunction

    function automatic int exp_sample(input int unsigned ph);
        real a;
        a = 2.0 * PI * real'((ph >> 16) & 255) / 256.0;
        return $rtoi($floor(2047.0 * $sin(a) + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Check one sample against the model, then advance the model.
    task automatic check_sample();
        int e, a, d;
        string tag;
        a = int'(smp_out);
        if (!tx_en) begin
            check(a == 0, "R6 idle zero", a, 0);
            ph_m = 0;
        end else begin
            e = exp_sample(ph_m);
            d = (a > e) ? a - e : e - a;
            if (!prev_en) tag = "R6 restart";
            else if (prev_bit != tx_bit || prev_mode != mode) tag = "R5 continuity";
            else case (mode)
                2'd0: tag = "R1 orig";
                2'd1: tag = "R2 answer";
                2'd2: tag = "R3 main";
                default: tag = "R4 back";
            endcase
            check(d <= 6, tag, a, e);
            check(a <= 2047 && a >= -2047, "R8 range", a, 2047);
            ph_m = (ph_m + step_of(mode, tx_bit)) & 32'h00FF_FFFF;
        end
        prev_en = tx_en; prev_bit = tx_bit; prev_mode = mode;
        n_samples++;
    endtask

    task automatic next_sample();
        @(negedge clk);
        while (!smp_valid) @(negedge clk);
        check_sample();
    endtask

    // Strobe spacing monitor.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (smp_valid) begin
                if (seen) check(gap == DIVB, "R7 spacing", gap, DIVB);
                seen = 1; gap = 1;
            end else gap++;
        end
    end

    initial begin
        int wd;
        for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(smp_out == 0, "R9 reset out", int'(smp_out), 0);
        check(smp_valid == 0, "R9 reset valid", int'(smp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(smp_out == 0, "R9 after release", int'(smp_out), 0);
        check(smp_valid == 0, "R9 after release valid", int'(smp_valid), 0);

        // Idle samples while disabled.
        for (int i = 0; i < 4; i++) next_sample();

        // Directed: each mode, alternating bits held for 8 samples.
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m); tx_en = 1'b1;
            for (int b = 0; b < 4; b++) begin
                tx_bit = b[0];
                for (int s = 0; s < 8; s++) next_sample();
            end
        end

        // Directed: back channel at 75 baud, 128 samples per bit (R4).
        mode = 2'd3;
        for (int b = 0; b < 3; b++) begin
            tx_bit = ~b[0];
            for (int s = 0; s < 128; s++) next_sample();
        end

        // Directed: disable then re-enable mid-tone (R6).
        tx_en = 1'b0; next_sample(); next_sample();
        tx_en = 1'b1; mode = 2'd2; tx_bit = 1'b1;
        for (int s = 0; s < 4; s++) next_sample();

        // Random stimulus.
        for (int s = 0; s < 2500; s++) begin
            if ($urandom_range(0, 3) == 0) tx_bit = ~tx_bit;
            if ($urandom_range(0, 40) == 0) mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 60) == 0) tx_en = ~tx_en;
            next_sample();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule